// File: doc/BRIEF.md
# RAMDAC Palette and Indirect Register Port

This block is the byte-wide host write port of a RAMDAC. The host reaches eight direct register slots through a 3-bit slot number. The slot number joins a bank bit, which comes from the DAC control register, with the two low bits of the access address. Two jobs sit behind those slots. The first is palette loading: the host sets an entry number, then streams colour bytes. The port gathers them three at a time and hands each finished entry, with an opaque alpha byte, to the palette RAM through a one-cycle commit strobe. The entry number advances after each commit.

The second job is a bank of indirect registers. These are reached by loading a 16-bit index in two byte halves and then writing a data byte. A few indirect registers have side effects. A write to the clock control register with its PLL-enable bit set extracts the pixel-clock PLL divider terms from the stored divider registers. The terms are presented as registered outputs with an update strobe, and the frequency division itself is left to the consumer. A write to the pixel format register either selects 8 bits per pixel and pulses a display-enable output, or flags a format that is not supported.

Top module: `ramdac_regport`

## Requirements
- R1: After reset, pal_we, pll_upd and disp_en are 0. The flags mask_warn, pll_src_err, fmt_bad and bpp8 are 0. The outputs pll_m, pll_vco_div and pll_ref_div are 0.
- R2: A write acts only when wr_size is 0, meaning a byte access. Sizes 1, 2 and 3 are dropped with no effect at all. The slot number is {dac_bank, wr_addr}. The slots are: 0 palette entry number, 1 palette colour data, 2 pixel mask, 4 index low byte, 5 index high byte, 6 index data. Slots 3 and 7 are ignored.
- R3: A write to slot 0 loads the palette entry number. It also restarts the colour component count, so the next slot 1 write is the first component.
- R4: The third slot 1 write after a restart or after a commit pulses pal_we for one cycle. With that pulse, pal_idx shows the entry number and pal_rgba shows {8'hFF, first, second, third}. The entry number then advances by one and wraps from 255 to 0. The first and second writes produce no pulse.
- R5: A slot 2 write of any value other than 8'hFF sets mask_warn, which stays set until reset. A write of 8'hFF leaves mask_warn unchanged.
- R6: A slot 6 write stores its byte at the indirect index {high, low}. An index with any bit set at or above position IND_AW drops the write.
- R7: A slot 6 write to index 16'h0002 with data bit 0 set, while index 16'h0010 holds bits [1:0] = 1, does three things. It pulses pll_upd for one cycle and sets pll_m = 8 >> r20[7:6], pll_vco_div = r20[5:0] + 65, and pll_ref_div = r21[4:0] * pll_m, where rNN is the byte held at index 16'h00NN. With data bit 0 clear, nothing changes.
- R8: If index 16'h0010 holds bits [1:0] other than 1 when such an enabled write arrives, pll_src_err is set and stays set until reset. In that case there is no pll_upd pulse and the terms do not change.
- R9: A slot 6 write of 3 to index 16'h000A sets bpp8 and pulses disp_en for one cycle. Any other value written there sets fmt_bad, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| dac_bank | input | 1 | Bank bit from the DAC control register, becomes slot bit 2 |
| wr_addr | input | 2 | Low access address bits, become slot bits 1:0 |
| wr_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 reserved |
| wr_data | input | 8 | Write data byte |
| pal_we | output | 1 | Palette entry commit strobe |
| pal_idx | output | 8 | Entry number of the committed entry |
| pal_rgba | output | 32 | Committed entry {alpha, c0, c1, c2} |
| mask_warn | output | 1 | Sticky: pixel mask written with a value other than 8'hFF |
| pll_m | output | 4 | PLL prescale term |
| pll_vco_div | output | 8 | PLL VCO divider term |
| pll_ref_div | output | 8 | PLL reference divider term |
| pll_upd | output | 1 | One-cycle strobe: PLL terms refreshed |
| pll_src_err | output | 1 | Sticky: PLL enabled with an unsupported source |
| bpp8 | output | 1 | 8 bits per pixel selected |
| disp_en | output | 1 | One-cycle display-enable pulse |
| fmt_bad | output | 1 | Sticky: unsupported pixel format written |

## Verification
A stale or skipped component count shows on the very next commit: pal_we pulses one write early or one write late, and the committed bytes are shuffled inside pal_rgba. A corrupted entry number shows in pal_idx on the next commit, and a wrong wrap shows after entry 255. A wrong index latch or a wrong file slot stays hidden until the next PLL enable or pixel format write, where the divider terms or the flags then disagree with the bytes the bench believes it stored. Every registered effect appears one clock after the write that caused it.

// File: rtl/ramdac_regport.sv
module ramdac_regport #(
  parameter int          IND_AW       = 8,
  parameter logic [15:0] CLK_CTL_IDX  = 16'h0002,
  parameter logic [15:0] PLL_CTL1_IDX = 16'h0010,
  parameter logic [15:0] F0M0_IDX     = 16'h0020,
  parameter logic [15:0] F1N0_IDX     = 16'h0021,
  parameter logic [15:0] PIXFMT_IDX   = 16'h000A,
  parameter int          PLL_EN_BIT   = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        dac_bank,
  input  logic [1:0]  wr_addr,
  input  logic [1:0]  wr_size,
  input  logic [7:0]  wr_data,
  output logic        pal_we,
  output logic [7:0]  pal_idx,
  output logic [31:0] pal_rgba,
  output logic        mask_warn,
  output logic [3:0]  pll_m,
  output logic [7:0]  pll_vco_div,
  output logic [7:0]  pll_ref_div,
  output logic        pll_upd,
  output logic        pll_src_err,
  output logic        bpp8,
  output logic        disp_en,
  output logic        fmt_bad
);
  localparam int IND_N = 1 << IND_AW;

  logic [7:0] ifile [IND_N];
  logic [7:0] ent_idx, comp0, comp1, idx_lo, idx_hi;
  logic [1:0] comp_cnt;

  wire        acc    = wr_en && (wr_size == 2'd0);
  wire [2:0]  slot   = {dac_bank, wr_addr};
  wire [15:0] iaddr  = {idx_hi, idx_lo};
  wire        ind_ok = (iaddr >> IND_AW) == 16'd0;
  wire        ind_wr = acc && (slot == 3'd6) && ind_ok;
  wire [IND_AW-1:0] islot = iaddr[IND_AW-1:0];

  wire [7:0] r_f0   = ifile[F0M0_IDX[IND_AW-1:0]];
  wire [7:0] r_f1   = ifile[F1N0_IDX[IND_AW-1:0]];
  wire [7:0] r_ctl1 = ifile[PLL_CTL1_IDX[IND_AW-1:0]];

  wire       pll_go = ind_wr && (iaddr == CLK_CTL_IDX) && wr_data[PLL_EN_BIT];
  wire       pf_wr  = ind_wr && (iaddr == PIXFMT_IDX);
  wire [3:0] m_n    = 4'd8 >> r_f0[7:6];
  wire [7:0] vco_n  = {2'b00, r_f0[5:0]} + 8'd65;
  wire [7:0] ref_n  = {3'b000, r_f1[4:0]} * {4'b0000, m_n};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_idx  <= '0;
      comp_cnt <= '0;
      comp0    <= '0;
      comp1    <= '0;
      pal_we   <= 1'b0;
      pal_idx  <= '0;
      pal_rgba <= '0;
    end else begin
      pal_we <= 1'b0;
      if (acc && slot == 3'd0) begin
        ent_idx  <= wr_data;
        comp_cnt <= 2'd0;
      end else if (acc && slot == 3'd1) begin
        case (comp_cnt)
          2'd0: begin comp0 <= wr_data; comp_cnt <= 2'd1; end
          2'd1: begin comp1 <= wr_data; comp_cnt <= 2'd2; end
          default: begin
            pal_we   <= 1'b1;
            pal_idx  <= ent_idx;
            pal_rgba <= {8'hFF, comp0, comp1, wr_data};
            ent_idx  <= ent_idx + 8'd1;
            comp_cnt <= 2'd0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_lo    <= '0;
      idx_hi    <= '0;
      mask_warn <= 1'b0;
      for (int i = 0; i < IND_N; i++) ifile[i] <= '0;
    end else if (acc) begin
      if (slot == 3'd2 && wr_data != 8'hFF) mask_warn <= 1'b1;
      if (slot == 3'd4) idx_lo <= wr_data;
      if (slot == 3'd5) idx_hi <= wr_data;
      if (ind_wr) ifile[islot] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pll_m       <= '0;
      pll_vco_div <= '0;
      pll_ref_div <= '0;
      pll_upd     <= 1'b0;
      pll_src_err <= 1'b0;
      bpp8        <= 1'b0;
      disp_en     <= 1'b0;
      fmt_bad     <= 1'b0;
    end else begin
      pll_upd <= 1'b0;
      disp_en <= 1'b0;
      if (pll_go) begin
        if (r_ctl1[1:0] == 2'd1) begin
          pll_upd     <= 1'b1;
          pll_m       <= m_n;
          pll_vco_div <= vco_n;
          pll_ref_div <= ref_n;
        end else begin
          pll_src_err <= 1'b1;
        end
      end
      if (pf_wr) begin
        if (wr_data == 8'd3) begin
          bpp8    <= 1'b1;
          disp_en <= 1'b1;
        end else begin
          fmt_bad <= 1'b1;
        end
      end
    end
  end

  assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_size == 2'd0) |=> !(pal_we || pll_upd || disp_en));
  assert_commit_cnt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pal_we |-> comp_cnt == 2'd0);
  assert_idx_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pal_we |-> ent_idx == pal_idx + 8'd1);
  assert_mask_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mask_warn |=> mask_warn);
  assert_terms_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pll_upd |-> ($onehot(pll_m) && pll_vco_div >= 8'd65 && pll_vco_div <= 8'd128));
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pll_src_err |=> pll_src_err);
  assert_disp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |-> bpp8);
endmodule

// File: tb/ramdac_regport_tb.sv
module ramdac_regport_tb_top;
  logic clk = 0, rst_n = 0, wr_en = 0, dac_bank = 0;
  logic [1:0] wr_addr = 0, wr_size = 0;
  logic [7:0] wr_data = 0;
  logic pal_we, mask_warn, pll_upd, pll_src_err, bpp8, disp_en, fmt_bad;
  logic [7:0] pal_idx, pll_vco_div, pll_ref_div;
  logic [31:0] pal_rgba;
  logic [3:0] pll_m;
  int vecs = 0, errs = 0;
  logic [7:0] m_idx, m_c0, m_c1;
  int m_cnt = 0;
  logic [7:0] s_f0, s_f1;

  always #10 clk = ~clk;

  ramdac_regport dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic bank, logic [1:0] a, logic [1:0] sz, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; dac_bank = bank; wr_addr = a; wr_size = sz; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic iw(logic [15:0] ix, logic [7:0] v);
    wr(1, 2'd0, 2'd0, ix[7:0]);
    wr(1, 2'd1, 2'd0, ix[15:8]);
    wr(1, 2'd2, 2'd0, v);
  endtask

  function automatic logic [3:0] e_m(logic [7:0] f0); return 4'd8 >> f0[7:6]; endfunction
  function automatic logic [7:0] e_vco(logic [7:0] f0); return 8'(f0[5:0]) + 8'd65; endfunction
  function automatic logic [7:0] e_ref(logic [7:0] f0, logic [7:0] f1);
    return 8'(f1[4:0]) * 8'(e_m(f0));
  endfunction

  task automatic pal_data(logic [7:0] d);
    wr(0, 2'd1, 2'd0, d);
    if (m_cnt == 0) begin m_c0 = d; m_cnt = 1; chk("R4 no commit c0", pal_we, 0); end
    else if (m_cnt == 1) begin m_c1 = d; m_cnt = 2; chk("R4 no commit c1", pal_we, 0); end
    else begin
      chk("R4 commit", pal_we, 1);
      chk("R4 idx", pal_idx, m_idx);
      chk("R4 rgba", pal_rgba, {8'hFF, m_c0, m_c1, d});
      m_idx = m_idx + 8'd1; m_cnt = 0;
    end
  endtask

  task automatic pal_addr(logic [7:0] d);
    wr(0, 2'd0, 2'd0, d);
    m_idx = d; m_cnt = 0;
  endtask

  task automatic pll_ok_check(string tag);
    chk({tag, " upd"}, pll_upd, 1);
    chk({tag, " m"}, pll_m, e_m(s_f0));
    chk({tag, " vco"}, pll_vco_div, e_vco(s_f0));
    chk({tag, " ref"}, pll_ref_div, e_ref(s_f0, s_f1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 pal_we", pal_we, 0);
    chk("R1 flags", {mask_warn, pll_src_err, fmt_bad, bpp8, pll_upd, disp_en}, 0);
    chk("R1 terms", {pll_m, pll_vco_div, pll_ref_div}, 0);

    // R3/R4 random palette streams
    for (int k = 0; k < 8; k++) begin
      pal_addr(8'($urandom));
      for (int j = 0; j < 1 + ($urandom % 10); j++) pal_data(8'($urandom));
    end
    // R4 wrap 255 -> 0
    pal_addr(8'd255);
    for (int j = 0; j < 6; j++) pal_data(8'($urandom));
    chk("R4 wrap", pal_idx, 8'd0);
    // R3 restart mid-entry
    pal_addr(8'd40);
    pal_data(8'h11);
    pal_addr(8'd7);
    pal_data(8'hA1); pal_data(8'hA2); pal_data(8'hA3);
    chk("R3 restart rgba", pal_rgba, 32'hFFA1A2A3);
    // R2 wide sizes and slots 3/7 dropped
    pal_addr(8'd90);
    pal_data(8'h01);
    for (int s = 1; s < 4; s++) begin
      wr(0, 2'd1, 2'(s), 8'h55);
      chk("R2 wide dropped", pal_we, 0);
    end
    wr(0, 2'd3, 2'd0, 8'h77); chk("R2 slot3", pal_we, 0);
    wr(1, 2'd3, 2'd0, 8'h77); chk("R2 slot7", pal_we, 0);
    wr(0, 2'd0, 2'd2, 8'h33); chk("R2 wide addr dropped", pal_we, 0);
    pal_data(8'h02); pal_data(8'h03);
    chk("R2 count intact", pal_rgba, 32'hFF010203);
    chk("R2 idx intact", pal_idx, 8'd90);

    // R5
    wr(0, 2'd2, 2'd0, 8'hFF); chk("R5 ff no warn", mask_warn, 0);
    wr(0, 2'd2, 2'd1, 8'h12); chk("R5 wide no warn", mask_warn, 0);
    wr(0, 2'd2, 2'd0, 8'h12); chk("R5 warn", mask_warn, 1);
    wr(0, 2'd2, 2'd0, 8'hFF); chk("R5 sticky", mask_warn, 1);

    // R6/R7 random PLL settings
    for (int k = 0; k < 16; k++) begin
      s_f0 = 8'($urandom); s_f1 = 8'($urandom);
      iw(16'h0020, s_f0);
      iw(16'h0021, s_f1);
      iw(16'h0010, {6'($urandom), 2'b01});
      iw(16'h0002, 8'($urandom) | 8'h01);
      pll_ok_check("R7");
      @(negedge clk); chk("R7 pulse one cycle", pll_upd, 0);
    end
    // R7 directed extremes
    s_f0 = 8'h3F; s_f1 = 8'h1F;
    iw(16'h0020, s_f0); iw(16'h0021, s_f1);
    iw(16'h0002, 8'h01);
    chk("R7 vco max", pll_vco_div, 8'd128);
    chk("R7 ref m8", pll_ref_div, 8'd248);
    s_f0 = 8'hC0; iw(16'h0020, s_f0); iw(16'h0002, 8'h01);
    pll_ok_check("R7 m1");
    // R7 enable clear
    iw(16'h0020, 8'h85);
    iw(16'h0002, 8'hFE);
    chk("R7 en clear no upd", pll_upd, 0);
    chk("R7 en clear m", pll_m, e_m(s_f0));
    s_f0 = 8'h85;
    iw(16'h0002, 8'h01);
    pll_ok_check("R6 stored");
    // R6 out-of-range index dropped
    iw(16'h0120, 8'h00);
    iw(16'h0002, 8'h01);
    pll_ok_check("R6 high index dropped");
    // R8
    iw(16'h0010, 8'h02);
    iw(16'h0020, 8'h11);
    iw(16'h0002, 8'h01);
    chk("R8 no upd", pll_upd, 0);
    chk("R8 err", pll_src_err, 1);
    chk("R8 terms held", pll_vco_div, e_vco(s_f0));
    iw(16'h0010, 8'h01);
    chk("R8 sticky", pll_src_err, 1);

    // R9
    iw(16'h000A, 8'h03);
    chk("R9 disp", disp_en, 1);
    chk("R9 bpp8", bpp8, 1);
    chk("R9 no bad", fmt_bad, 0);
    @(negedge clk); chk("R9 disp one cycle", disp_en, 0);
    iw(16'h000A, 8'h05);
    chk("R9 bad disp", disp_en, 0);
    chk("R9 bad", fmt_bad, 1);
    iw(16'h000A, 8'h03);
    chk("R9 bad sticky", fmt_bad, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule